// File: doc/BRIEF.md
# Companion GPIO and Control Register Block

This block is a small memory-mapped peripheral that sits beside a host processor. The host reaches it over a plain register bus: an address, write data, a write enable, a read enable, and combinational read data. It holds eleven 16-bit registers in a 4 KB window. Most of these registers are storage only: mode, card-detect, card control, the three interrupt words and a readback word. The status register is fixed, and the power register has a write side effect.

Two of the registers drive sixteen general-purpose output lines. One register holds the direction of each line, and the other holds its level. A line is driven high only when both its level bit and its direction bit are 1. Each time the host writes either register, the block works out the new driven value. For one cycle it then pulses a change strobe on every line whose driven value has changed. A separate per-line input lets external logic set or clear individual level bits. This input never raises a strobe itself. Its effect on the pins appears at the next write to the direction or level register.

Top module: `companion_gpio_regs`

## Requirements
- R1: In reset, and after reset until a write, every register reads 0 except status, which reads 0x0002. `pin_out` and `chg_stb` are 0, and no strobe fires while reset is held.
- R2: The registers sit at word offsets: mode 0x00, card-detect 0x04, status 0x08, power 0x0C, card control 0x10, irq raw 0x14, irq mask 0x18, irq status 0x1C, direction 0x20, level 0x24, readback 0x28. Each storage register reads back the last value written to it.
- R3: Only bits 15:0 of `bus_wdata` are stored. Bits 31:16 are discarded.
- R4: A power write stores the value. If bit 7 of the value is 1, bits 15 and 6 are also set (OR with 0x8040).
- R5: Writes to the status offset have no effect, and status keeps reading 0x0002.
- R6: A level write stores the written value ANDed with the current direction register.
- R7: In the cycle after a direction or level write, `pin_out` equals level AND direction. At no other time does `pin_out` change.
- R8: On the same edge, `chg_stb` pulses for one cycle on exactly the bits where the new `pin_out` differs from the old one. A write that changes no driven bit gives no strobe.
- R9: When `pin_set_en[n]` is 1, level bit n is loaded from `pin_set_val[n]`. This gives no strobe and no `pin_out` change until the next direction or level write.
- R10: Offsets above 0x28, or offsets not word-aligned, are unmapped. Reads there return 0, and writes there change nothing.
- R11: When a bus level write and a pin event land in the same cycle, the bus write decides the whole level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (12) | Byte offset inside the window |
| bus_wdata | input | BUS_W (32) | Write data; low 16 bits used |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_re | input | 1 | Read enable; gates `bus_rdata` |
| bus_rdata | output | 16 | Combinational read data, 0 when not reading a mapped offset |
| pin_set_en | input | 16 | Per-line load enable for the level register |
| pin_set_val | input | 16 | Per-line value loaded when enabled |
| pin_out | output | 16 | Driven line levels (level AND direction) |
| chg_stb | output | 16 | One-cycle per-line change strobe |

## Verification
The output path is tried with several patterns. Direction is widened and narrowed under a fixed level, which separates masking at store time from masking at drive time. The same level is written twice, so a strobe that fires on every write is caught where a strobe that fires only on toggles stays quiet. Pin events that set bits outside the current direction are followed by a direction write, which shows that those events change the pins only late, and only through the masking. Power writes with bit 7 high and low, writes carrying junk in the upper half-word, status writes, and misaligned or out-of-window accesses each cover one side effect or guard of the register file.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  localparam int DW   = 16;
  localparam int NREG = 11;
  localparam int IDXW = 4;

  typedef enum logic [IDXW-1:0] {
    RI_MODE    = 4'd0,
    RI_CDET    = 4'd1,
    RI_STAT    = 4'd2,
    RI_PWR     = 4'd3,
    RI_CARDCTL = 4'd4,
    RI_IRQRAW  = 4'd5,
    RI_IRQMASK = 4'd6,
    RI_IRQSTAT = 4'd7,
    RI_DIR     = 4'd8,
    RI_LVL     = 4'd9,
    RI_RDBK    = 4'd10
  } reg_idx_e;

  localparam logic [DW-1:0] STAT_RST  = 16'h0002;
  localparam int            PWR_TRIG  = 7;
  localparam logic [DW-1:0] PWR_FORCE = 16'h8040;
endpackage

// File: rtl/cgr_addr_dec.sv
module cgr_addr_dec
  import cgr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDXW-1:0]   idx
);
  localparam int WW = ADDR_W - 2;

  always_comb begin
    hit = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] < WW'(NREG));
    idx = addr[IDXW+1:2];
  end
endmodule

// File: rtl/cgr_gpio_core.sv
module cgr_gpio_core
  import cgr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dir,
  input  logic          wr_lvl,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] pin_set_en,
  input  logic [DW-1:0] pin_set_val,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] lvl_q,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] chg_stb
);
  logic [DW-1:0] dir_n, lvl_n, eff_n;
  logic          upd;

  always_comb begin
    dir_n = wr_dir ? wr_data : dir_q;
    lvl_n = (lvl_q & ~pin_set_en) | (pin_set_val & pin_set_en);
    if (wr_lvl) lvl_n = wr_data & dir_q;
    eff_n = lvl_n & dir_n;
    upd   = wr_dir | wr_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      lvl_q   <= '0;
      pin_out <= '0;
      chg_stb <= '0;
    end else begin
      dir_q <= dir_n;
      lvl_q <= lvl_n;
      if (upd) begin
        pin_out <= eff_n;
        chg_stb <= eff_n ^ pin_out;
      end else begin
        chg_stb <= '0;
      end
    end
  end
endmodule

// File: rtl/cgr_store_bank.sv
module cgr_store_bank
  import cgr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [DW-1:0]            dir_in,
  input  logic [DW-1:0]            lvl_in,
  output logic [NREG-1:0][DW-1:0]  q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(RI_STAT)) begin : g_stat
      assign q[i] = STAT_RST;
    end else if (i == int'(RI_DIR)) begin : g_dir
      assign q[i] = dir_in;
    end else if (i == int'(RI_LVL)) begin : g_lvl
      assign q[i] = lvl_in;
    end else begin : g_store
      logic [DW-1:0] val;
      logic [DW-1:0] nxt;
      always_comb begin
        nxt = wr_data;
        if (i == int'(RI_PWR) && wr_data[PWR_TRIG]) nxt = wr_data | PWR_FORCE;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              val <= '0;
        else if (wr_en && wr_idx == IDXW'(i))    val <= nxt;
      end
      assign q[i] = val;
    end
  end
endmodule

// File: rtl/companion_gpio_regs.sv
module companion_gpio_regs
  import cgr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pin_set_en,
  input  logic [DW-1:0]     pin_set_val,
  output logic [DW-1:0]     pin_out,
  output logic [DW-1:0]     chg_stb
);
  logic                    hit;
  logic [IDXW-1:0]         idx;
  logic [DW-1:0]           wd16;
  logic                    unused_hi;
  logic                    wr_any, wr_dir, wr_lvl;
  logic [DW-1:0]           dir_q, lvl_q;
  logic [NREG-1:0][DW-1:0] rq;

  assign wd16      = bus_wdata[DW-1:0];
  assign unused_hi = ^bus_wdata[BUS_W-1:DW];

  cgr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .idx  (idx)
  );

  always_comb begin
    wr_any = bus_we && hit;
    wr_dir = wr_any && (idx == RI_DIR);
    wr_lvl = wr_any && (idx == RI_LVL);
  end

  cgr_gpio_core u_gpio (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_dir      (wr_dir),
    .wr_lvl      (wr_lvl),
    .wr_data     (wd16),
    .pin_set_en  (pin_set_en),
    .pin_set_val (pin_set_val),
    .dir_q       (dir_q),
    .lvl_q       (lvl_q),
    .pin_out     (pin_out),
    .chg_stb     (chg_stb)
  );

  cgr_store_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_any),
    .wr_idx  (idx),
    .wr_data (wd16),
    .dir_in  (dir_q),
    .lvl_in  (lvl_q),
    .q       (rq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re && hit) bus_rdata = rq[idx];
  end
endmodule

// File: rtl/cgr_checker.sv
module cgr_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [15:0]       bus_rdata,
  input logic [15:0]       pin_out,
  input logic [15:0]       chg_stb
);
  logic gpio_wr;
  assign gpio_wr = bus_we && (bus_addr == ADDR_W'('h20) || bus_addr == ADDR_W'('h24));

  // R1: quiet outputs while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (chg_stb == 16'h0 && pin_out == 16'h0));

  // R5: status always reads the ready value
  p_stat_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'('h08)) |-> bus_rdata == 16'h0002);

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (bus_addr[1:0] != 2'b00 || bus_addr > ADDR_W'('h28))) |-> bus_rdata == 16'h0);

  // R8: strobes mark exactly the toggled lines
  p_stb_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_stb != 16'h0) |-> chg_stb == (pin_out ^ $past(pin_out)));

  // R7: pins hold and strobes stay low without a direction/level write
  p_hold_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gpio_wr) |-> ($stable(pin_out) && chg_stb == 16'h0));
endmodule

bind companion_gpio_regs cgr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .chg_stb   (chg_stb)
);

// File: tb/companion_gpio_regs_tb.sv
module companion_gpio_regs_tb;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [15:0] bus_rdata, pin_set_en, pin_set_val, pin_out, chg_stb;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];

  // bench model state
  logic [15:0] m_reg [0:10];
  logic [15:0] m_dir, m_lvl, m_out;

  companion_gpio_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_set_en(pin_set_en), .pin_set_val(pin_set_val),
    .pin_out(pin_out), .chg_stb(chg_stb)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [11:0] a);
    return (a[1:0] == 2'b00) && (a <= 12'h028);
  endfunction

  function automatic logic [15:0] model_read(input logic [11:0] a);
    if (!mapped(a)) return 16'h0;
    case (a[5:2])
      4'd2:    return 16'h0002;
      4'd8:    return m_dir;
      4'd9:    return m_lvl;
      default: return m_reg[a[5:2]];
    endcase
  endfunction

  // one bus cycle: drive, update model, queue expected outputs after the edge
  task automatic cycle(input logic we, input logic re, input logic [11:0] a,
                       input logic [31:0] wd, input logic [15:0] pen, input logic [15:0] pval,
                       input bit chk_rd, input string tag);
    logic [15:0] w16, dir_n, lvl_n, stb, eff;
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
    pin_set_en = pen; pin_set_val = pval;
    if (chk_rd) begin
      #1;
      check(bus_rdata == model_read(a), tag, bus_rdata, model_read(a));
    end
    w16   = wd[15:0];
    dir_n = m_dir;
    lvl_n = (m_lvl & ~pen) | (pval & pen);
    stb   = 16'h0;
    if (we && mapped(a)) begin
      case (a[5:2])
        4'd2: ;
        4'd3: m_reg[3] = w16[7] ? (w16 | 16'h8040) : w16;
        4'd8: dir_n = w16;
        4'd9: lvl_n = w16 & m_dir;
        default: m_reg[a[5:2]] = w16;
      endcase
      if (a[5:2] == 4'd8 || a[5:2] == 4'd9) begin
        eff   = lvl_n & dir_n;
        stb   = eff ^ m_out;
        m_out = eff;
      end
    end
    m_dir = dir_n;
    m_lvl = lvl_n;
    exp_q.push_back({stb, m_out});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cycle(1'b1, 1'b0, a, d, 16'h0, 16'h0, 1'b0, "");
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    cycle(1'b0, 1'b1, a, 32'h0, 16'h0, 16'h0, 1'b1, tag);
  endtask
  task automatic pin_evt(input logic [15:0] en, input logic [15:0] v);
    cycle(1'b0, 1'b0, 12'h0, 32'h0, en, v, 1'b0, "");
  endtask

  // monitor: compares queued expectations between edges (R7 R8)
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() != 0) begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(pin_out == e[15:0],  "R7 pin_out", pin_out, e[15:0]);
        check(chg_stb == e[31:16], "R8 chg_stb", chg_stb, e[31:16]);
      end
    end
  end

  initial begin
    #(CLK_P*50000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    pin_set_en = '0; pin_set_val = '0;
    for (int i = 0; i < 11; i++) m_reg[i] = 16'h0;
    m_dir = 0; m_lvl = 0; m_out = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pin_out == 16'h0 && chg_stb == 16'h0, "R1 outputs in reset", pin_out | chg_stb, 16'h0);
    rst_n = 1'b1;

    // R1 R2: reset values of every register
    for (int i = 0; i < 11; i++) rd(12'(i*4), "R1 reset value");

    // R2 R3: storage registers with junk in the upper half-word
    wr(12'h000, 32'hABCD_1111); wr(12'h004, 32'h5555_2222);
    wr(12'h010, 32'hFFFF_3333); wr(12'h014, 32'h0001_4444);
    wr(12'h018, 32'h8000_5555); wr(12'h01C, 32'h1234_6666);
    wr(12'h028, 32'hDEAD_7777);
    foreach (m_reg[i]) rd(12'(i*4), "R2 R3 readback");

    // R4: power side effect
    wr(12'h00C, 32'h0000_0080); rd(12'h00C, "R4 power bit7 set");
    wr(12'h00C, 32'h0000_1234); rd(12'h00C, "R4 power bit7 clear");
    wr(12'h00C, 32'hFFFF_0F9F); rd(12'h00C, "R4 power mixed");

    // R5: status ignores writes
    wr(12'h008, 32'h0000_FFFF); rd(12'h008, "R5 status after write");

    // R6 R7 R8: direction / level interplay
    wr(12'h020, 32'h0000_00FF);
    wr(12'h024, 32'h0000_FFFF); rd(12'h024, "R6 level masked");
    wr(12'h020, 32'h0000_0F0F);
    wr(12'h024, 32'h0000_0F0F); rd(12'h024, "R6 level masked 2");
    wr(12'h024, 32'h0000_0F0F);
    wr(12'h020, 32'h0000_0000);
    wr(12'h020, 32'h0000_0F0F);

    // R9: pin events load level silently
    pin_evt(16'hF000, 16'hF000); rd(12'h024, "R9 level after pin set");
    pin_evt(16'h0003, 16'h0000); rd(12'h024, "R9 level after pin clear");
    wr(12'h020, 32'h0000_FFFF);  rd(12'h020, "R9 dir readback");

    // R11: bus level write wins over a same-cycle pin event
    cycle(1'b1, 1'b0, 12'h024, 32'h0000_1234, 16'hFFFF, 16'hFFFF, 1'b0, "");
    rd(12'h024, "R11 bus wins");

    // R10: unmapped and misaligned accesses
    wr(12'h02C, 32'h0000_FFFF); wr(12'h021, 32'h0000_0000);
    wr(12'h100, 32'h0000_AAAA); wr(12'h002, 32'h0000_5555);
    rd(12'h02C, "R10 read above map"); rd(12'h021, "R10 misaligned read");
    rd(12'hFFC, "R10 top of window");
    for (int i = 0; i < 11; i++) rd(12'(i*4), "R10 registers untouched");

    cycle(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 16'h0, 1'b0, "");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule